// File: doc/BRIEF.md
# Parity-Checked Line Receive Engine

This engine gathers one line of text from an incoming byte stream and writes it into a small local buffer memory. Each byte holds a 7-bit character in its low bits. The top bit makes the parity of the whole byte even. The engine checks parity on every accepted byte. A good byte is stored with its top bit forced to zero. A bad byte is not stored, and the engine stops with an error flag raised.

A line ends in one of two ways. The first is a carriage return: the engine stores it, writes a line feed into the next buffer location in the following cycle, and reports a complete line. The second is a character limit: if that many characters arrive without a carriage return, the engine stops and reports an overflow.

Software or a controller fires a one-cycle start pulse to begin a line and then reads the completion code and the stored byte count. A clear input returns the engine to idle from any state.

Top module: `line_rx_engine`

## Requirements
- R1: After reset the completion code is 0, the count is 0, the parity-error flag is low, `in_ready_o` is low and no buffer write occurs.
- R2: A start pulse is accepted in the idle, done and error states. It sets the count and write address to 0, sets the code to 0, drops the error flag and raises `in_ready_o` from the next cycle.
- R3: An accepted byte whose eight bits hold an even number of ones is written in the same cycle. It goes to buffer address equal to the current count, with bit 7 cleared, and the count then rises by one.
- R4: An accepted byte with an odd number of ones is not written. The engine enters the error state: the error flag goes high, the count is kept, the code stays 0 and `in_ready_o` goes low.
- R5: When the stored character is a carriage return (0x0D), the cycle after writes a line feed (0x0A) at the next address, with `in_ready_o` low in that cycle.
- R6: After the line feed the code becomes 2 (complete line), and the count includes both the carriage return and the line feed.
- R7: When the 81st stored character (parameter `CHAR_LIMIT`) is not a carriage return, the code becomes 1 (overflow), the count is 81 and `in_ready_o` goes low.
- R8: A carriage return arriving as the 81st character ends the line as complete: code 2, count 82, and the line feed lands at address 81.
- R9: In the done and error states the stream input is ignored (no writes, count held) until a new start. A start pulse while receiving has no effect.
- R10: Clear returns the engine to idle from any state, with code 0, count 0, error flag low and `in_ready_o` low. Clear wins over a start in the same cycle.
- R11: The completion code is 0 in every state except done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse that begins a new line |
| clear_i | input | 1 | Returns the engine to idle |
| in_data_i | input | 8 | Received byte: character in bits 6:0, parity in bit 7 |
| in_valid_i | input | 1 | Byte on `in_data_i` is valid |
| in_ready_o | output | 1 | Engine accepts a byte this cycle |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | 7 | Buffer write address |
| buf_wdata_o | output | 8 | Buffer write data, bit 7 always 0 |
| done_code_o | output | 2 | 0 idle/busy/error, 1 overflow, 2 complete line |
| char_count_o | output | 7 | Number of bytes stored in this line |
| parity_err_o | output | 1 | High in the error state after a bad-parity byte |

## Verification
Carriage-return termination and the character-limit overflow can both apply to the same accepted byte: a carriage return that is also the 81st character. The bench feeds 80 ordinary characters and then a carriage return. It expects the complete-line result, with the line feed written at address 81 and a count of 82. It also runs a separate line of 81 plain characters that must end in overflow with a count of 81. A second collision, clear and start pulsed in the same cycle, must leave the engine idle.

// File: rtl/lre_pkg.sv
`timescale 1ns/1ps
package lre_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RECV = 3'd1,
    ST_LF   = 3'd2,
    ST_DONE = 3'd3,
    ST_ERR  = 3'd4
  } lre_state_e;

  typedef enum logic [1:0] {
    CODE_NONE = 2'd0,
    CODE_OVF  = 2'd1,
    CODE_LINE = 2'd2
  } lre_code_e;

  localparam logic [7:0] CHAR_CR = 8'h0D;
  localparam logic [7:0] CHAR_LF = 8'h0A;

endpackage

// File: rtl/lre_rst_sync.sv
`timescale 1ns/1ps
module lre_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/lre_parity_chk.sv
`timescale 1ns/1ps
module lre_parity_chk
  import lre_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              par_ok_o,
  output logic [BYTE_W-1:0] char_o,
  output logic              is_cr_o
);

  localparam int CHAR_W = BYTE_W - 1;

  // Even parity over the whole byte: XOR of all bits is zero.
  assign par_ok_o = ~(^byte_i);
  assign char_o   = {1'b0, byte_i[CHAR_W-1:0]};
  assign is_cr_o  = (char_o == CHAR_CR);

endmodule

// File: rtl/lre_fsm.sv
`timescale 1ns/1ps
module lre_fsm
  import lre_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       clear_i,
  input  logic       in_valid_i,
  input  logic       par_ok_i,
  input  logic       is_cr_i,
  input  logic       at_limit_i,
  output logic       in_ready_o,
  output logic       store_o,
  output logic       app_lf_o,
  output logic       ptr_clr_o,
  output logic [1:0] code_o,
  output logic       perr_o
);

  lre_state_e state_q, state_d;
  lre_code_e  code_q, code_d;
  logic       perr_q, perr_d;
  logic       upd_en;

  always_comb begin
    state_d   = state_q;
    code_d    = code_q;
    perr_d    = perr_q;
    store_o   = 1'b0;
    app_lf_o  = 1'b0;
    ptr_clr_o = 1'b0;
    if (clear_i) begin
      state_d   = ST_IDLE;
      code_d    = CODE_NONE;
      perr_d    = 1'b0;
      ptr_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start_i) begin
            state_d   = ST_RECV;
            code_d    = CODE_NONE;
            perr_d    = 1'b0;
            ptr_clr_o = 1'b1;
          end
        end
        ST_RECV: begin
          if (in_valid_i) begin
            if (!par_ok_i) begin
              state_d = ST_ERR;
              perr_d  = 1'b1;
            end else begin
              store_o = 1'b1;
              if (is_cr_i) begin
                state_d = ST_LF;
              end else if (at_limit_i) begin
                state_d = ST_DONE;
                code_d  = CODE_OVF;
              end
            end
          end
        end
        ST_LF: begin
          app_lf_o = 1'b1;
          state_d  = ST_DONE;
          code_d   = CODE_LINE;
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  assign upd_en = (state_d != state_q) || (code_d != code_q) || (perr_d != perr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= CODE_NONE;
      perr_q  <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      code_q  <= code_d;
      perr_q  <= perr_d;
    end
  end

  assign in_ready_o = (state_q == ST_RECV);
  assign code_o     = code_q;
  assign perr_o     = perr_q;

  AST_LF_FOLLOWS_CR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o && is_cr_i && !clear_i) |=> app_lf_o); // R5
  AST_LF_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_lf_o |=> !app_lf_o); // R5
  AST_CODE_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != CODE_NONE) |-> (state_q == ST_DONE)); // R11
  AST_PERR_IN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_q |-> (state_q == ST_ERR)); // R4
  AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECV && start_i && !clear_i && !in_valid_i) |=> (state_q == ST_RECV)); // R9

endmodule

// File: rtl/lre_wr_port.sv
`timescale 1ns/1ps
module lre_wr_port
  import lre_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int CHAR_LIMIT = 81,
  parameter int BUF_DEPTH  = CHAR_LIMIT + 1,
  parameter int ADDR_W     = $clog2(BUF_DEPTH),
  parameter int CNT_W      = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_clr_i,
  input  logic              store_i,
  input  logic              app_lf_i,
  input  logic [BYTE_W-1:0] char_i,
  output logic              at_limit_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(CHAR_LIMIT - 1);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(BUF_DEPTH);

  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  assign we_o   = store_i | app_lf_i;
  assign ptr_en = ptr_clr_i | we_o;

  always_comb begin
    if (ptr_clr_i) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign at_limit_o = (ptr_q == LIMIT_M1);
  assign addr_o     = ptr_q[ADDR_W-1:0];
  assign wdata_o    = app_lf_i ? CHAR_LF : char_i;
  assign count_o    = ptr_q;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (ptr_q < DEPTH_C)); // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q)) |-> ((ptr_q == $past(ptr_q) + CNT_W'(1)) || (ptr_q == '0))); // R3

endmodule

// File: rtl/line_rx_engine.sv
`timescale 1ns/1ps
module line_rx_engine
  import lre_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int CHAR_LIMIT = 81,
  parameter int BUF_DEPTH  = CHAR_LIMIT + 1,
  parameter int ADDR_W     = $clog2(BUF_DEPTH),
  parameter int CNT_W      = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [BYTE_W-1:0] buf_wdata_o,
  output logic [1:0]        done_code_o,
  output logic [CNT_W-1:0]  char_count_o,
  output logic              parity_err_o
);

  logic              rst_n;
  logic              par_ok;
  logic [BYTE_W-1:0] char_w;
  logic              is_cr;
  logic              at_limit;
  logic              store;
  logic              app_lf;
  logic              ptr_clr;

  lre_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  lre_parity_chk #(.BYTE_W(BYTE_W)) u_par (
    .byte_i   (in_data_i),
    .par_ok_o (par_ok),
    .char_o   (char_w),
    .is_cr_o  (is_cr)
  );

  lre_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .in_valid_i (in_valid_i),
    .par_ok_i   (par_ok),
    .is_cr_i    (is_cr),
    .at_limit_i (at_limit),
    .in_ready_o (in_ready_o),
    .store_o    (store),
    .app_lf_o   (app_lf),
    .ptr_clr_o  (ptr_clr),
    .code_o     (done_code_o),
    .perr_o     (parity_err_o)
  );

  lre_wr_port #(
    .BYTE_W     (BYTE_W),
    .CHAR_LIMIT (CHAR_LIMIT),
    .BUF_DEPTH  (BUF_DEPTH),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W)
  ) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ptr_clr_i  (ptr_clr),
    .store_i    (store),
    .app_lf_i   (app_lf),
    .char_i     (char_w),
    .at_limit_o (at_limit),
    .we_o       (buf_we_o),
    .addr_o     (buf_addr_o),
    .wdata_o    (buf_wdata_o),
    .count_o    (char_count_o)
  );

  AST_BAD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_valid_i && in_ready_o && !par_ok) |-> !buf_we_o); // R4
  AST_OVF_COUNT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_code_o == CODE_OVF) |-> (char_count_o == CNT_W'(CHAR_LIMIT))); // R7
  AST_WDATA_TOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    buf_we_o |-> !buf_wdata_o[BYTE_W-1]); // R3

endmodule

// File: tb/line_rx_engine_tb_top.sv
`timescale 1ns/1ps
module line_rx_engine_tb_top;

  logic       clk;
  logic       arst_n;
  logic       start;
  logic       clear;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_ready_o;
  logic       buf_we_o;
  logic [6:0] buf_addr_o;
  logic [7:0] buf_wdata_o;
  logic [1:0] done_code_o;
  logic [6:0] char_count_o;
  logic       parity_err_o;

  int n_checks = 0;
  int n_err    = 0;
  int exp_ptr  = 0;
  logic [14:0] exp_q[$];

  line_rx_engine dut_i (
    .clk_i        (clk),
    .arst_ni      (arst_n),
    .start_i      (start),
    .clear_i      (clear),
    .in_data_i    (in_data),
    .in_valid_i   (in_valid),
    .in_ready_o   (in_ready_o),
    .buf_we_o     (buf_we_o),
    .buf_addr_o   (buf_addr_o),
    .buf_wdata_o  (buf_wdata_o),
    .done_code_o  (done_code_o),
    .char_count_o (char_count_o),
    .parity_err_o (parity_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] good(input logic [6:0] c);
    return {^c, c};
  endfunction

  function automatic logic [7:0] bad(input logic [6:0] c);
    return {~(^c), c};
  endfunction

  // Monitor: pops the scoreboard on every buffer write.
  always @(negedge clk) begin
    if (arst_n && buf_we_o) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected buffer write", 1, 0);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        check("R3 write address", int'(buf_addr_o), int'(e[14:8]));
        check("R3 write data", int'(buf_wdata_o), int'(e[7:0]));
        if (e[7:0] == 8'h0A) check("R5 ready low during line feed", int'(in_ready_o), 0);
      end
    end
  end

  task automatic pulse(input logic do_start, input logic do_clear);
    @(posedge clk); #1;
    start = do_start;
    clear = do_clear;
    @(posedge clk); #1;
    start = 1'b0;
    clear = 1'b0;
    if (do_start || do_clear) exp_ptr = 0;
  endtask

  // Driver: pushes expected writes, then hands the byte over.
  task automatic send_byte(input logic [7:0] b);
    int w;
    @(posedge clk); #1;
    in_data  = b;
    in_valid = 1'b1;
    if (^b == 1'b0) begin
      exp_q.push_back({7'(exp_ptr), 1'b0, b[6:0]});
      exp_ptr++;
      if (b[6:0] == 7'h0D) begin
        exp_q.push_back({7'(exp_ptr), 8'h0A});
        exp_ptr++;
      end
    end
    w = 0;
    @(negedge clk);
    while (!in_ready_o && w < 100) begin
      w++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    arst_n = 1'b0; start = 1'b0; clear = 1'b0; in_data = '0; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 arst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 code", int'(done_code_o), 0);
    check("R1 count", int'(char_count_o), 0);
    check("R1 perr", int'(parity_err_o), 0);
    check("R1 ready", int'(in_ready_o), 0);

    // Short line ending in CR
    pulse(1'b1, 1'b0);
    @(negedge clk);
    check("R2 ready after start", int'(in_ready_o), 1);
    check("R2 count after start", int'(char_count_o), 0);
    send_byte(good(7'h48));
    send_byte(good(7'h69));
    @(negedge clk);
    check("R11 code while receiving", int'(done_code_o), 0);
    check("R3 count after two", int'(char_count_o), 2);
    send_byte(good(7'h0D));
    settle();
    check("R6 code line", int'(done_code_o), 2);
    check("R6 count with LF", int'(char_count_o), 4);
    check("R9 ready low in done", int'(in_ready_o), 0);
    check("R5 scoreboard drained", exp_q.size(), 0);

    // Input ignored while done
    @(posedge clk); #1;
    in_data = good(7'h41); in_valid = 1'b1;
    repeat (5) @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R9 count held in done", int'(char_count_o), 4);

    // Overflow: 81 plain characters
    pulse(1'b1, 1'b0);
    @(negedge clk);
    check("R2 code cleared by start", int'(done_code_o), 0);
    for (int i = 0; i < 81; i++) send_byte(good(7'(8'h41 + (i % 26))));
    settle();
    check("R7 code overflow", int'(done_code_o), 1);
    check("R7 count", int'(char_count_o), 81);
    check("R7 ready low", int'(in_ready_o), 0);
    check("R7 scoreboard drained", exp_q.size(), 0);

    // CR as the 81st character
    pulse(1'b1, 1'b0);
    for (int i = 0; i < 80; i++) send_byte(good(7'(8'h61 + (i % 26))));
    send_byte(good(7'h0D));
    settle();
    check("R8 code line at limit", int'(done_code_o), 2);
    check("R8 count", int'(char_count_o), 82);
    check("R8 scoreboard drained", exp_q.size(), 0);

    // Parity error
    pulse(1'b1, 1'b0);
    send_byte(good(7'h31));
    send_byte(good(7'h32));
    send_byte(bad(7'h33));
    @(negedge clk);
    check("R4 perr", int'(parity_err_o), 1);
    check("R4 count kept", int'(char_count_o), 2);
    check("R4 code", int'(done_code_o), 0);
    check("R4 ready low", int'(in_ready_o), 0);

    // Start from error, then start while busy ignored
    pulse(1'b1, 1'b0);
    @(negedge clk);
    check("R2 perr cleared by start", int'(parity_err_o), 0);
    send_byte(good(7'h5A));
    pulse(1'b1, 1'b0);
    exp_ptr = 1;
    @(negedge clk);
    check("R9 start ignored count", int'(char_count_o), 1);
    check("R9 start ignored ready", int'(in_ready_o), 1);

    // Clear and start together
    pulse(1'b1, 1'b1);
    @(negedge clk);
    check("R10 ready after clear", int'(in_ready_o), 0);
    check("R10 count after clear", int'(char_count_o), 0);

    // Clear from error
    pulse(1'b1, 1'b0);
    send_byte(bad(7'h20));
    pulse(1'b0, 1'b1);
    @(negedge clk);
    check("R10 perr after clear", int'(parity_err_o), 0);
    check("R10 code after clear", int'(done_code_o), 0);
    check("R10 scoreboard drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule